// File: doc/BRIEF.md
# Arithmetic Status Flags Unit

This block is an add/subtract datapath with its own status and control flag register. Each clock, a 4-bit opcode selects one action. The action is either an addition or subtraction of two operands, or a direct manipulation of the flag register. Add and subtract write a result register and refresh six condition flags: carry, parity, auxiliary carry, zero, sign and overflow. The other opcodes work on the flags alone:

- set, clear or toggle the carry flag;
- set or clear the direction flag;
- set or clear the interrupt and trap bits, which are plain storage with no side effects;
- restore five condition flags from an input byte.

The current condition flags are always visible as a packed byte with a fixed layout that includes constant bits. Software-style code can save that byte and later feed it back through the restore opcode. All state is registered, so an action's effect appears on the outputs one clock after the opcode is presented.

Top module: `status_flag_alu`

## Requirements
- R1: After reset, the result is 0, every flag is 0 and the packed byte reads 0x02.
- R2: Opcode 0x1 (add): one clock later the result is (a + b) mod 2^DATA_W. CF is the carry out of the top bit and AF is the carry out of bit 3.
- R3: Opcode 0x2 (subtract): one clock later the result is (a − b) mod 2^DATA_W. CF is 1 exactly when a < b unsigned, and AF is 1 exactly when a[3:0] < b[3:0].
- R4: After add or subtract, ZF is 1 when the result is zero and SF equals the result's top bit. PF is 1 when the low byte of the result holds an even number of ones.
- R5: After add, OF is 1 when both operands share a sign and the result's sign differs from it. After subtract, OF follows the same rule with the second operand negated.
- R6: Opcode 0x3 sets CF and opcode 0x4 clears CF. Opcode 0x5 inverts CF. None of these three changes any other flag or the result.
- R7: Opcode 0x6 clears DF (forward) and opcode 0x7 sets DF (backward).
- R8: The packed byte, from bit 7 down to bit 0, is SF, ZF, 0, AF, 0, PF, 1, CF, and always reflects the current flags.
- R9: Opcode 0x8 (restore) loads SF, ZF, AF, PF and CF from bits 7, 6, 4, 2 and 0 of the restore byte. OF, DF, IF, TF and the result are left unchanged.
- R10: Opcodes 0x9 and 0xA set and clear IF. Opcodes 0xB and 0xC set and clear TF. None of them has any other effect.
- R11: Opcode 0x0 and the unused opcodes 0xD to 0xF change nothing. Opcodes other than add and subtract never change the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Opcode for this cycle |
| a_i | input | DATA_W | First operand |
| b_i | input | DATA_W | Second operand |
| byte_i | input | 8 | Byte consumed by the restore opcode |
| result_o | output | DATA_W | Registered add/subtract result |
| cf_o | output | 1 | Carry/borrow flag |
| pf_o | output | 1 | Parity flag |
| af_o | output | 1 | Auxiliary (nibble) carry flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| of_o | output | 1 | Signed overflow flag |
| df_o | output | 1 | Direction flag |
| if_o | output | 1 | Interrupt enable bit |
| tf_o | output | 1 | Trap bit |
| packed_o | output | 8 | Packed condition flags |

## Verification
The hardest state to reach from the ports is a mix of flags that no single arithmetic operation leaves behind. One such mix is OF set while the packed byte is all zero apart from its constant bit. Another is DF set across a restore and a later arithmetic operation. The stimulus builds these states in a chain. A subtraction that overflows is followed by a restore from a byte whose only ones sit in the constant positions. Separately, DF is raised before a restore from 0xFF. Checking after each step shows that the restore touched only its five fields and that the constant bits of the packed byte never follow the input.

// File: rtl/sflag_pkg.sv
package sflag_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_NOP   = 4'h0,
      OP_ADD   = 4'h1,
      OP_SUB   = 4'h2,
      OP_CSET  = 4'h3,
      OP_CCLR  = 4'h4,
      OP_CFLIP = 4'h5,
      OP_DFWD  = 4'h6,
      OP_DBWD  = 4'h7,
      OP_LOADB = 4'h8,
      OP_ISET  = 4'h9,
      OP_ICLR  = 4'hA,
      OP_TSET  = 4'hB,
      OP_TCLR  = 4'hC
   } op_e;

   typedef struct packed {
      logic cf;
      logic pf;
      logic af;
      logic zf;
      logic sf;
      logic of;
      logic df;
      logic ien;
      logic tf;
   } flags_t;

   // bit positions inside the packed byte
   localparam int PK_SF = 7;
   localparam int PK_ZF = 6;
   localparam int PK_Z5 = 5;
   localparam int PK_AF = 4;
   localparam int PK_Z3 = 3;
   localparam int PK_PF = 2;
   localparam int PK_ONE = 1;
   localparam int PK_CF = 0;
endpackage

// File: rtl/sflag_addsub.sv
module sflag_addsub #(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              carry_o,
   output logic              nib_carry_o,
   output logic              b_eff_msb_o
);
   localparam int MSB = DATA_W - 1;
   localparam int NIB = 4;

   logic [DATA_W-1:0] b_eff;
   assign b_eff       = sub_i ? ~b_i : b_i;
   assign b_eff_msb_o = b_eff[MSB];

   if (RIPPLE) begin : g_ripple
      logic [DATA_W:0]   c;
      logic [DATA_W-1:0] s;
      assign c[0] = sub_i;
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         assign s[i]   = a_i[i] ^ b_eff[i] ^ c[i];
         assign c[i+1] = (a_i[i] & b_eff[i]) | (c[i] & (a_i[i] ^ b_eff[i]));
      end
      assign sum_o       = s;
      assign carry_o     = c[DATA_W];
      assign nib_carry_o = c[NIB];
   end else begin : g_behav
      logic [DATA_W:0] full;
      logic [NIB:0]    low;
      assign full = {1'b0, a_i} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_i};
      assign low  = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, sub_i};
      assign sum_o       = full[DATA_W-1:0];
      assign carry_o     = full[DATA_W];
      assign nib_carry_o = low[NIB];
   end
endmodule

// File: rtl/sflag_cond.sv
module sflag_cond #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] sum_i,
   input  logic              carry_i,
   input  logic              nib_carry_i,
   input  logic              sub_i,
   input  logic              a_msb_i,
   input  logic              b_eff_msb_i,
   output logic              cf_o,
   output logic              af_o,
   output logic              of_o,
   output logic              zf_o,
   output logic              sf_o,
   output logic              pf_o
);
   localparam int MSB = DATA_W - 1;

   // a subtract is an add of the inverse plus one: the raw carry is the inverted borrow
   assign cf_o = carry_i ^ sub_i;
   assign af_o = nib_carry_i ^ sub_i;
   assign of_o = (a_msb_i == b_eff_msb_i) && (sum_i[MSB] != a_msb_i);
   assign zf_o = (sum_i == '0);
   assign sf_o = sum_i[MSB];
   assign pf_o = ~(^sum_i[7:0]);
endmodule

// File: rtl/sflag_pack.sv
module sflag_pack
   import sflag_pkg::*;
(
   input  flags_t      cur_i,
   input  logic [7:0]  byte_i,
   output logic [7:0]  packed_o,
   output flags_t      restored_o
);
   always_comb begin
      packed_o         = '0;
      packed_o[PK_SF]  = cur_i.sf;
      packed_o[PK_ZF]  = cur_i.zf;
      packed_o[PK_Z5]  = 1'b0;
      packed_o[PK_AF]  = cur_i.af;
      packed_o[PK_Z3]  = 1'b0;
      packed_o[PK_PF]  = cur_i.pf;
      packed_o[PK_ONE] = 1'b1;
      packed_o[PK_CF]  = cur_i.cf;
   end

   always_comb begin
      restored_o    = cur_i;
      restored_o.sf = byte_i[PK_SF];
      restored_o.zf = byte_i[PK_ZF];
      restored_o.af = byte_i[PK_AF];
      restored_o.pf = byte_i[PK_PF];
      restored_o.cf = byte_i[PK_CF];
   end
endmodule

// File: rtl/status_flag_alu.sv
module status_flag_alu
   import sflag_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [7:0]        byte_i,
   output logic [DATA_W-1:0] result_o,
   output logic              cf_o,
   output logic              pf_o,
   output logic              af_o,
   output logic              zf_o,
   output logic              sf_o,
   output logic              of_o,
   output logic              df_o,
   output logic              if_o,
   output logic              tf_o,
   output logic [7:0]        packed_o
);
   localparam int MSB = DATA_W - 1;

   if (DATA_W < 8) begin : g_width_chk
      $error("status_flag_alu: DATA_W must be at least 8");
   end

   op_e               op;
   flags_t            flg_q, flg_d, restored;
   logic [DATA_W-1:0] res_q, res_d, sum;
   logic              is_sub, carry, nib_carry, b_eff_msb;
   logic              c_cf, c_af, c_of, c_zf, c_sf, c_pf;

   assign op     = op_e'(op_i);
   assign is_sub = (op == OP_SUB);

   sflag_addsub #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) u_addsub (
      .a_i         (a_i),
      .b_i         (b_i),
      .sub_i       (is_sub),
      .sum_o       (sum),
      .carry_o     (carry),
      .nib_carry_o (nib_carry),
      .b_eff_msb_o (b_eff_msb)
   );

   sflag_cond #(.DATA_W(DATA_W)) u_cond (
      .sum_i       (sum),
      .carry_i     (carry),
      .nib_carry_i (nib_carry),
      .sub_i       (is_sub),
      .a_msb_i     (a_i[MSB]),
      .b_eff_msb_i (b_eff_msb),
      .cf_o        (c_cf),
      .af_o        (c_af),
      .of_o        (c_of),
      .zf_o        (c_zf),
      .sf_o        (c_sf),
      .pf_o        (c_pf)
   );

   sflag_pack u_pack (
      .cur_i      (flg_q),
      .byte_i     (byte_i),
      .packed_o   (packed_o),
      .restored_o (restored)
   );

   always_comb begin
      flg_d = flg_q;
      res_d = res_q;
      case (op)
         OP_ADD, OP_SUB: begin
            res_d    = sum;
            flg_d.cf = c_cf;
            flg_d.af = c_af;
            flg_d.of = c_of;
            flg_d.zf = c_zf;
            flg_d.sf = c_sf;
            flg_d.pf = c_pf;
         end
         OP_CSET:  flg_d.cf  = 1'b1;
         OP_CCLR:  flg_d.cf  = 1'b0;
         OP_CFLIP: flg_d.cf  = ~flg_q.cf;
         OP_DFWD:  flg_d.df  = 1'b0;
         OP_DBWD:  flg_d.df  = 1'b1;
         OP_LOADB: flg_d     = restored;
         OP_ISET:  flg_d.ien = 1'b1;
         OP_ICLR:  flg_d.ien = 1'b0;
         OP_TSET:  flg_d.tf  = 1'b1;
         OP_TCLR:  flg_d.tf  = 1'b0;
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flg_q <= '0;
         res_q <= '0;
      end else begin
         flg_q <= flg_d;
         res_q <= res_d;
      end
   end

   assign result_o = res_q;
   assign cf_o     = flg_q.cf;
   assign pf_o     = flg_q.pf;
   assign af_o     = flg_q.af;
   assign zf_o     = flg_q.zf;
   assign sf_o     = flg_q.sf;
   assign of_o     = flg_q.of;
   assign df_o     = flg_q.df;
   assign if_o     = flg_q.ien;
   assign tf_o     = flg_q.tf;
endmodule

// File: rtl/status_flag_alu_chk.sv
module status_flag_alu_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        op_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [7:0]        byte_i,
   input logic [DATA_W-1:0] result_o,
   input logic              cf_o,
   input logic              zf_o,
   input logic              sf_o,
   input logic              of_o,
   input logic              df_o,
   input logic              if_o,
   input logic              tf_o,
   input logic [7:0]        packed_o
);
   logic [DATA_W-1:0] add_ref;
   assign add_ref = a_i + b_i;

   p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h1 |=> result_o == $past(add_ref));

   p_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h2 |=> cf_o == $past(a_i < b_i));

   p_zero_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'h1 || op_i == 4'h2) |=>
         (zf_o == (result_o == '0)) && (sf_o == result_o[DATA_W-1]));

   p_cset_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h3 |=> cf_o);

   p_cclr_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h4 |=> !cf_o);

   p_cflip_r6: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h5 |=> cf_o != $past(cf_o));

   p_dfwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h6 |=> !df_o);

   p_dbwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h7 |=> df_o);

   p_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h8 |=>
         packed_o[7] == $past(byte_i[7]) && packed_o[6] == $past(byte_i[6]) &&
         packed_o[4] == $past(byte_i[4]) && packed_o[2] == $past(byte_i[2]) &&
         packed_o[0] == $past(byte_i[0]) &&
         $stable(of_o) && $stable(df_o) && $stable(if_o) && $stable(tf_o) &&
         $stable(result_o));

   p_iset_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'h9 |=> if_o);

   p_tclr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      op_i == 4'hC |=> !tf_o);

   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'h0 || op_i >= 4'hD) |=>
         $stable(result_o) && $stable(packed_o) && $stable(of_o) &&
         $stable(df_o) && $stable(if_o) && $stable(tf_o));
endmodule

bind status_flag_alu status_flag_alu_chk #(.DATA_W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_i     (op_i),
   .a_i      (a_i),
   .b_i      (b_i),
   .byte_i   (byte_i),
   .result_o (result_o),
   .cf_o     (cf_o),
   .zf_o     (zf_o),
   .sf_o     (sf_o),
   .of_o     (of_o),
   .df_o     (df_o),
   .if_o     (if_o),
   .tf_o     (tf_o),
   .packed_o (packed_o)
);

// File: tb/test_status_flag_alu.sv
module test_status_flag_alu;
   localparam int CLK_PERIOD = 10;
   localparam int N_ROWS     = 26;
   localparam int WATCHDOG   = 20000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] op_i = 4'h0;
   logic [7:0] a_i = '0, b_i = '0, byte_i = '0;
   logic [7:0] result_o, packed_o;
   logic       cf_o, pf_o, af_o, zf_o, sf_o, of_o, df_o, if_o, tf_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   status_flag_alu i_status_flag_alu (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .a_i(a_i), .b_i(b_i), .byte_i(byte_i),
      .result_o(result_o), .cf_o(cf_o), .pf_o(pf_o), .af_o(af_o), .zf_o(zf_o),
      .sf_o(sf_o), .of_o(of_o), .df_o(df_o), .if_o(if_o), .tf_o(tf_o),
      .packed_o(packed_o)
   );

   // row: op, a, b, byte, expected result, expected packed, expected {of,df,if,tf}
   localparam logic [47:0] TBL [0:N_ROWS-1] = '{
      {4'h1, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h57, 4'b0000},
      {4'h1, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h92, 4'b1000},
      {4'h2, 8'h00, 8'h01, 8'h00, 8'hFF, 8'h97, 4'b0000},
      {4'h2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h12, 4'b1000},
      {4'h1, 8'h12, 8'h34, 8'h00, 8'h46, 8'h02, 4'b0000},
      {4'h3, 8'h00, 8'h00, 8'h00, 8'h46, 8'h03, 4'b0000},
      {4'h5, 8'h00, 8'h00, 8'h00, 8'h46, 8'h02, 4'b0000},
      {4'h5, 8'h00, 8'h00, 8'h00, 8'h46, 8'h03, 4'b0000},
      {4'h4, 8'h00, 8'h00, 8'h00, 8'h46, 8'h02, 4'b0000},
      {4'h7, 8'h00, 8'h00, 8'h00, 8'h46, 8'h02, 4'b0100},
      {4'h8, 8'h00, 8'h00, 8'hFF, 8'h46, 8'hD7, 4'b0100},
      {4'h1, 8'h5A, 8'hA5, 8'h00, 8'hFF, 8'h86, 4'b0100},
      {4'h6, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h86, 4'b0000},
      {4'h2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h12, 4'b1000},
      {4'h8, 8'h00, 8'h00, 8'h28, 8'h7F, 8'h02, 4'b1000},
      {4'h9, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h02, 4'b1010},
      {4'hB, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h02, 4'b1011},
      {4'h0, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'h02, 4'b1011},
      {4'hF, 8'hFF, 8'hFF, 8'hFF, 8'h7F, 8'h02, 4'b1011},
      {4'hA, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h02, 4'b1001},
      {4'hC, 8'h00, 8'h00, 8'h00, 8'h7F, 8'h02, 4'b1000},
      {4'h2, 8'h05, 8'h05, 8'h00, 8'h00, 8'h46, 4'b0000},
      {4'h2, 8'h10, 8'h01, 8'h00, 8'h0F, 8'h16, 4'b0000},
      {4'h1, 8'h08, 8'h08, 8'h00, 8'h10, 8'h12, 4'b0000},
      {4'h3, 8'h00, 8'h00, 8'h00, 8'h10, 8'h13, 4'b0000},
      {4'h1, 8'h01, 8'h01, 8'h00, 8'h02, 8'h02, 4'b0000}
   };

   function automatic string req_of(logic [3:0] op);
      case (op)
         4'h1:             return "R2 R4 R5";
         4'h2:             return "R3 R4 R5";
         4'h3, 4'h4, 4'h5: return "R6";
         4'h6, 4'h7:       return "R7";
         4'h8:             return "R9";
         4'h9, 4'hA, 4'hB, 4'hC: return "R10";
         default:          return "R11";
      endcase
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // checks result, the separate flag pins (via the R8 layout) and the packed byte
   task automatic check_state(input string req, input logic [7:0] e_res,
                              input logic [7:0] e_pk, input logic [3:0] e_misc);
      logic [7:0] from_pins;
      from_pins = {sf_o, zf_o, 1'b0, af_o, 1'b0, pf_o, 1'b1, cf_o};
      check(result_o == e_res && {of_o, df_o, if_o, tf_o} == e_misc, req,
            {20'h0, result_o, of_o, df_o, if_o, tf_o}, {20'h0, e_res, e_misc});
      check(from_pins == e_pk, req, {24'h0, from_pins}, {24'h0, e_pk});
      check(packed_o == e_pk, "R8", {24'h0, packed_o}, {24'h0, e_pk});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      check_state("R1", 8'h00, 8'h02, 4'b0000);

      for (int i = 0; i < N_ROWS; i++) begin
         {op_i, a_i, b_i, byte_i} = TBL[i][47:20];
         @(negedge clk);
         check_state(req_of(TBL[i][47:44]), TBL[i][19:12], TBL[i][11:4], TBL[i][3:0]);
      end

      // directed: restore ignores the constant positions (R9, R8)
      op_i = 4'h8; byte_i = 8'h2A;
      @(negedge clk);
      check_state("R9", 8'h02, 8'h02, 4'b0000);

      // directed: toggle after restore that set CF (R6)
      op_i = 4'h8; byte_i = 8'h01;
      @(negedge clk);
      op_i = 4'h5;
      @(negedge clk);
      check_state("R6", 8'h02, 8'h02, 4'b0000);

      // directed: reset in mid-run returns to the reset state (R1)
      op_i = 4'h7;
      @(negedge clk);
      op_i = 4'h0;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      check_state("R1", 8'h00, 8'h02, 4'b0000);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule